// File: doc/BRIEF.md
# Translation-Miss Context Register Pair

This block holds the two system-control registers that a 64-bit memory-management unit consults when a translation misses. The first is a virtual-page-high register. It carries the even/odd page-pair number (VPN2) and an 8-bit address-space identifier in its low byte. The second is an extended context register. It combines a software-owned page-table base with the region bits and the VPN2 of the faulting address, so that a miss handler can index its page table directly.

Two sources update the pair. Software writes through a write-enable, a one-bit register select and a 64-bit data word, and each register applies its own write mask. A translation fault loads both registers from the faulting virtual address in one cycle. The width of the implemented segment, `SEG_BITS`, is a parameter. Pages are fixed at 4 KB. The field boundaries of the extended context register move with `SEG_BITS`. A combinational read port returns either register under a read select.

Top module: `ctx_update_unit`

## Requirements
- R1: After a synchronous reset both registers read back as zero.
- R2: A software write with select 0 loads the page-high register with the write data, with bits 12:8 forced to zero and every bit outside the segment mask forced to zero. The segment mask keeps bits 63:62 and bits SEG_BITS-1:0.
- R3: A fault loads the page-high register as follows. Bits 7:0 keep their previous value. Bits 12:8 become zero. All other bits come from the fault address, and the segment mask is then applied.
- R4: A fault leaves extended-context bits 63 down to SEG_BITS-7 unchanged.
- R5: On a fault, fault-address bits 47:46 are shifted right by SEG_BITS-9 and ORed into the extended-context value.
- R6: On a fault, fault-address bits SEG_BITS-1:13 are shifted right by 9 and ORed into the extended-context value. Every other bit below SEG_BITS-7 becomes zero, including bits 3:0.
- R7: A software write with select 1 keeps extended-context bits SEG_BITS-8:0 and takes all higher bits from the write data.
- R8: When a fault and a software write occur in the same cycle, the fault update is applied to both registers and the write is discarded.
- R9: The read port returns the page-high register when the read select is 0 and the extended context register when it is 1. An update applied at a clock edge is visible right after that edge.
- R10: With no fault and no write, both registers hold. A software write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | Write target: 0 page-high, 1 extended context |
| wr_data | input | 64 | Software write data |
| flt_en | input | 1 | Translation fault strobe |
| flt_addr | input | 64 | Faulting virtual address |
| rd_sel | input | 1 | Read target: 0 page-high, 1 extended context |
| rd_data | output | 64 | Combinational read data |

## Verification
Each update, from a write or from a fault, lands at the clock edge where its strobe is sampled. The new value is therefore due on the read port immediately after that edge, and the hold cases are due on the same edge. The bench drives its stimulus on the falling edge and advances its reference model on the rising edge. It then reads both registers a few nanoseconds later by toggling the read select, so the expected value always refers to the edge that has just passed. Directed vectors cover all-ones and all-zero addresses, collisions between a write and a fault, and hold cycles. A run of pseudo-random cycles covers the remaining patterns.

// File: rtl/ctxu_pkg.sv
package ctxu_pkg;

    localparam int unsigned XLEN     = 64;
    localparam int unsigned ASID_W   = 8;
    localparam int unsigned PG_SHIFT = 12;

    typedef enum logic {
        SEL_VHI  = 1'b0,
        SEL_XCTX = 1'b1
    } ctx_sel_e;

    typedef struct packed {
        logic            en;
        ctx_sel_e        sel;
        logic [XLEN-1:0] data;
    } sw_wr_t;

    typedef struct packed {
        logic            en;
        logic [XLEN-1:0] vaddr;
    } fault_t;

    // upper two region bits plus the implemented segment
    function automatic logic [XLEN-1:0] seg_mask(int unsigned seg);
        logic [XLEN-1:0] low;
        low = (64'd1 << seg) - 64'd1;
        return {2'b11, {(XLEN-2){1'b0}}} | low;
    endfunction

    // clears the sub-page-pair hole between the ASID and the VPN2
    function automatic logic [XLEN-1:0] vhi_write_mask();
        logic [XLEN-1:0] m;
        m = '1;
        m[PG_SHIFT:ASID_W] = '0;
        return m;
    endfunction

endpackage

// File: rtl/ctxu_vhi_reg.sv
module ctxu_vhi_reg
    import ctxu_pkg::*;
#(
    parameter int unsigned SEG_BITS = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  sw_wr_t          wr,
    input  fault_t          flt,
    output logic [XLEN-1:0] q
);
    localparam logic [XLEN-1:0] SMASK = seg_mask(SEG_BITS);
    localparam logic [XLEN-1:0] WMASK = vhi_write_mask();

    logic            wr_hit;
    logic [XLEN-1:0] nxt;

    assign wr_hit = wr.en && (wr.sel == SEL_VHI);

    always_comb begin
        nxt = q;
        if (flt.en) begin
            nxt = {flt.vaddr[XLEN-1:PG_SHIFT+1], {(PG_SHIFT+1-ASID_W){1'b0}},
                   q[ASID_W-1:0]} & SMASK;
        end else if (wr_hit) begin
            nxt = wr.data & WMASK & SMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assert_asid_kept_R3: assert property (@(posedge clk) disable iff (rst)
        flt.en |=> q[ASID_W-1:0] == $past(q[ASID_W-1:0]));

    assert_hole_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (q[PG_SHIFT:ASID_W] == '0) && ((q & ~SMASK) == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!flt.en && !wr_hit) |=> $stable(q));

endmodule

// File: rtl/ctxu_xctx_reg.sv
module ctxu_xctx_reg
    import ctxu_pkg::*;
#(
    parameter int unsigned SEG_BITS    = 40,
    parameter logic [63:0] REGION_PICK = 64'h0000_C000_0000_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  sw_wr_t          wr,
    input  fault_t          flt,
    output logic [XLEN-1:0] q
);
    localparam int unsigned BASE_LSB  = SEG_BITS - 7;
    localparam int unsigned REG_SHIFT = SEG_BITS - 9;
    localparam int unsigned VPN_SHIFT = 9;
    localparam logic [XLEN-1:0] SW_KEEP  = (64'd1 << BASE_LSB) - 64'd1;
    localparam logic [XLEN-1:0] VPN_PICK = ((64'd1 << SEG_BITS) - 64'd1)
                                           & ~((64'd1 << (PG_SHIFT+1)) - 64'd1);

    logic            wr_hit;
    logic [XLEN-1:0] region_f;
    logic [XLEN-1:0] vpn_f;
    logic [XLEN-1:0] nxt;

    assign wr_hit   = wr.en && (wr.sel == SEL_XCTX);
    assign region_f = (flt.vaddr & REGION_PICK) >> REG_SHIFT;
    assign vpn_f    = (flt.vaddr & VPN_PICK) >> VPN_SHIFT;

    always_comb begin
        nxt = q;
        if (flt.en) begin
            nxt = (q & ~SW_KEEP) | region_f | vpn_f;
        end else if (wr_hit) begin
            nxt = (q & SW_KEEP) | (wr.data & ~SW_KEEP);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assert_base_kept_R4: assert property (@(posedge clk) disable iff (rst)
        flt.en |=> q[XLEN-1:BASE_LSB] == $past(q[XLEN-1:BASE_LSB]));

    assert_low_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !flt.en) |=> q[BASE_LSB-1:0] == $past(q[BASE_LSB-1:0]));

    assert_fault_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (flt.en && wr_hit) |=> q[3:0] == 4'd0);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!flt.en && !wr_hit) |=> $stable(q));

endmodule

// File: rtl/ctxu_rd_mux.sv
module ctxu_rd_mux
    import ctxu_pkg::*;
(
    input  ctx_sel_e        sel,
    input  logic [XLEN-1:0] vhi,
    input  logic [XLEN-1:0] xctx,
    output logic [XLEN-1:0] dout
);
    always_comb begin
        case (sel)
            SEL_VHI:  dout = vhi;
            SEL_XCTX: dout = xctx;
            default:  dout = '0;
        endcase
    end

    assert_rd_route_R9: assert final ((sel == SEL_XCTX) ? (dout == xctx) : (dout == vhi));

endmodule

// File: rtl/ctx_update_unit.sv
module ctx_update_unit
    import ctxu_pkg::*;
#(
    parameter int unsigned SEG_BITS = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [63:0] wr_data,
    input  logic        flt_en,
    input  logic [63:0] flt_addr,
    input  logic        rd_sel,
    output logic [63:0] rd_data
);
    sw_wr_t          wr_req;
    fault_t          flt_req;
    logic [XLEN-1:0] vhi_q;
    logic [XLEN-1:0] xctx_q;

    assign wr_req  = '{en: wr_en, sel: ctx_sel_e'(wr_sel), data: wr_data};
    assign flt_req = '{en: flt_en, vaddr: flt_addr};

    ctxu_vhi_reg #(.SEG_BITS(SEG_BITS)) u_vhi (
        .clk (clk),
        .rst (rst),
        .wr  (wr_req),
        .flt (flt_req),
        .q   (vhi_q)
    );

    ctxu_xctx_reg #(.SEG_BITS(SEG_BITS)) u_xctx (
        .clk (clk),
        .rst (rst),
        .wr  (wr_req),
        .flt (flt_req),
        .q   (xctx_q)
    );

    ctxu_rd_mux u_rd (
        .sel  (ctx_sel_e'(rd_sel)),
        .vhi  (vhi_q),
        .xctx (xctx_q),
        .dout (rd_data)
    );

endmodule

// File: tb/ctx_update_unit_bench.sv
`timescale 1ns/1ps
module ctx_update_unit_bench;
    localparam int SEG = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sel = 1'b0, flt_en = 1'b0, rd_sel = 1'b0;
    logic [63:0] wr_data = '0, flt_addr = '0, rd_data;

    int n_run = 0, n_fail = 0;
    logic [63:0] m_hi = '0, m_xc = '0;

    always #5 clk = ~clk;

    ctx_update_unit #(.SEG_BITS(SEG)) u_ctx_update_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flt_en(flt_en), .flt_addr(flt_addr), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [63:0] segm();
        logic [63:0] m;
        for (int i = 0; i < 64; i++) m[i] = (i >= 62) || (i < SEG);
        return m;
    endfunction

    task automatic check(string tag, logic sel, logic [63:0] exp);
        rd_sel = sel;
        #1;
        n_run++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", tag, sel, rd_data, exp);
        end
    endtask

    task automatic step(string tag, logic we, logic ws, logic [63:0] wd,
                        logic fe, logic [63:0] fa);
        logic [63:0] nh, nx, keep_lo;
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = wd; flt_en = fe; flt_addr = fa;
        nh = m_hi; nx = m_xc;
        keep_lo = (64'd1 << (SEG - 7)) - 1;
        if (fe) begin
            nh = ((m_hi & 64'hFF) | (fa & ~64'h1FFF)) & segm();
            nx = (m_xc & ~keep_lo)
               | ((fa & 64'h0000_C000_0000_0000) >> (SEG - 9))
               | ((fa & ((64'd1 << SEG) - 1) & ~64'h1FFF) >> 9);
        end else if (we && !ws) begin
            nh = wd & ~64'h1F00 & segm();
        end else if (we && ws) begin
            nx = (m_xc & keep_lo) | (wd & ~keep_lo);
        end
        @(posedge clk);
        m_hi = nh; m_xc = nx;
        #2;
        wr_en = 1'b0; flt_en = 1'b0;
        check({tag, " hi"}, 1'b0, m_hi);
        check({tag, " xctx"}, 1'b1, m_xc);
    endtask

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset", 1'b0, 64'd0);
        check("R1 reset", 1'b1, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        step("R2 write hi ones", 1, 0, '1, 0, '0);
        check("R2 hi literal", 1'b0, 64'hC000_00FF_FFFF_E0FF);
        step("R7 write xctx ones", 1, 1, '1, 0, '0);
        check("R7 xctx literal", 1'b1, 64'hFFFF_FFFE_0000_0000);
        step("R10 hold", 0, 0, 64'h1234, 0, '0);
        step("R2 write hi pattern", 1, 0, 64'h5A5A_A5A5_1234_5678, 0, '0);
        step("R3 R4 R5 R6 fault ones", 0, 0, '0, 1, '1);
        check("R5 R6 xctx literal", 1'b1, 64'hFFFF_FFFE_7FFF_FFF0);
        step("R3 R6 fault mid", 0, 0, '0, 1, 64'h0000_0012_3456_789A);
        step("R7 write xctx zero", 1, 1, '0, 0, '0);
        step("R8 collide hi", 1, 0, 64'hFFFF_0000_FFFF_0000, 1, 64'h4000_4000_8765_4321);
        step("R8 collide xctx", 1, 1, '1, 1, 64'hC000_C0AB_CDEF_0123);
        step("R10 other untouched", 1, 0, 64'h0F0F_0F0F_0F0F_0F0F, 0, '0);
        step("R9 R3 fault zero", 0, 0, '0, 1, '0);
        for (int k = 0; k < 60; k++) begin
            step("R2 R3 R4 R5 R6 R7 R8 R10 random", 1'($urandom), 1'($urandom),
                 {$urandom, $urandom}, 1'($urandom), {$urandom, $urandom});
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule